// File: doc/BRIEF.md
# Five-Phase Multicycle Integer Core

A 32-bit integer processor core that does not overlap instructions. Every instruction walks through five phases of one clock each: fetch, decode with register read, execute or address generation, memory access or branch resolution, and register write-back. A new instruction is fetched every fifth cycle. Values travel between phases only through named holding registers: the instruction register, the next-sequential PC, the two operand latches, the extended immediate, the ALU result, the load data latch and a one-bit branch condition.

The core has separate instruction and data ports. Both are word wide and both answer within the same cycle. Addresses are byte addresses in big-endian order, so the byte at the lowest address sits in the most significant lane of a word. Only aligned word accesses are legal. A misaligned load or store is dropped and flagged instead. The register file has 32 entries, and entry 0 is a constant zero. The core serves as a small control processor wherever a simple schedule matters more than throughput.

Top module: `mcore_top`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 (RESET_PC), and dmem_re_o, dmem_we_o and misalign_o are all low. The first cycle after reset is a fetch cycle.
- R2: Each phase lasts exactly one cycle, in the order fetch, decode, execute, memory, write-back. imem_req_o is high only in the fetch cycle, so three instructions take 15 cycles and fetches happen at cycles 0, 5, 10 and 15 after reset.
- R3: The PC (imem_addr_o) changes only at the end of the memory phase. The next-sequential value is the fetch address plus 4.
- R4: R-type instructions have opcode 0x00, and the function code sits in bits [5:0]. The codes are ADD 0x20, SUB 0x22, AND 0x24, OR 0x25, XOR 0x26, SLL 0x04, SRL 0x06, SRA 0x07 and signed SLT 0x2A. Shift amounts come from rs2[4:0].
- R5: Immediate ALU opcodes are ADDI 0x08, SUBI 0x0A, ANDI 0x0C, ORI 0x0D, XORI 0x0E and signed SLTI 0x18. The 16-bit immediate is always sign-extended, including for the logic operations.
- R6: The fields are opcode [31:26], rs1 [25:21], rs2 or I-type destination [20:16], R-type destination [15:11] and immediate [15:0]. R-type results go to [15:11]. Immediate results and load data go to [20:16].
- R7: Register 0 always reads as zero, and any write to it is discarded.
- R8: LW (0x23) and SW (0x2B) use the address rs1 + sext(imm). SW stores the register named in [20:16].
- R9: BEQZ (0x04) and BNEZ (0x05) test rs1 against zero. A taken branch goes to PC+4+sext(imm); a branch that is not taken goes to PC+4.
- R10: J (0x02) always goes to PC+4+sext(bits [25:0]). An offset of -4 jumps to itself.
- R11: A load or store whose address has bits [1:0] not equal to zero raises misalign_o for the memory-phase cycle only. It drives neither dmem_re_o nor dmem_we_o, and a misaligned load leaves its destination unchanged.
- R12: An unknown opcode, an unknown function code, or an R-type word with nonzero bits [10:6] writes no register and makes no data access. The PC still advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_req_o | output | 1 | Instruction fetch strobe, high in the fetch phase |
| imem_addr_o | output | 32 | Instruction byte address (the PC) |
| imem_rdata_i | input | 32 | Instruction word, valid in the same cycle |
| dmem_re_o | output | 1 | Data read strobe for aligned loads |
| dmem_we_o | output | 1 | Data write strobe for aligned stores |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdata_i | input | 32 | Load data, valid in the same cycle |
| misalign_o | output | 1 | One-cycle flag for a dropped misaligned access |

## Verification
The bench checks results that only a correct design gets right:
- Signed and unsigned comparisons that disagree: a core that compared unsigned would store 1 where 0 is expected.
- Shift amounts with stray high bits: these catch a core that shifts by the whole operand.
- Logic immediates with bit 15 set: these expose zero-extension.
- R-type and I-type destination fields that point at different registers: a core that swapped them would write the wrong register and store a stale value.
- Fetch addresses sampled cycle by cycle: a PC updated early, or a sixth phase, shows up at once.
- Taken and untaken branches of both senses, a forward jump, a self-jump and a negative store offset: a core with a wrong target or a wrong sign extension would land on a poisoned instruction.
- Misaligned and undefined instructions: a core that still touched memory or wrote the register file would change either the write count or the stored value.

// File: rtl/mcore_pkg.sv
package mcore_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  typedef enum logic [2:0] {
    PH_IF  = 3'd0,
    PH_ID  = 3'd1,
    PH_EX  = 3'd2,
    PH_MEM = 3'd3,
    PH_WB  = 3'd4
  } phase_e;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT
  } alu_op_e;

  typedef enum logic [2:0] {
    K_NOP, K_REG, K_IMM, K_LOAD, K_STORE, K_BRZ, K_BRNZ, K_JUMP
  } kind_e;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_J    = 6'h02;
  localparam logic [5:0] OPC_BEQZ = 6'h04;
  localparam logic [5:0] OPC_BNEZ = 6'h05;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SUBI = 6'h0A;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_SLTI = 6'h18;
  localparam logic [5:0] OPC_LW   = 6'h23;
  localparam logic [5:0] OPC_SW   = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h04;
  localparam logic [5:0] FN_SRL = 6'h06;
  localparam logic [5:0] FN_SRA = 6'h07;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
(
  input  logic [5:0]  opc_i,
  input  logic [10:0] fn_i,   // shamt [10:6] + func [5:0]
  output kind_e       kind_o,
  output alu_op_e     op_o
);
  always_comb begin
    kind_o = K_NOP;
    op_o   = ALU_ADD;
    unique case (opc_i)
      OPC_REG: begin
        kind_o = (fn_i[10:6] == 5'd0) ? K_REG : K_NOP;
        unique case (fn_i[5:0])
          FN_ADD:  op_o = ALU_ADD;
          FN_SUB:  op_o = ALU_SUB;
          FN_AND:  op_o = ALU_AND;
          FN_OR:   op_o = ALU_OR;
          FN_XOR:  op_o = ALU_XOR;
          FN_SLL:  op_o = ALU_SLL;
          FN_SRL:  op_o = ALU_SRL;
          FN_SRA:  op_o = ALU_SRA;
          FN_SLT:  op_o = ALU_SLT;
          default: kind_o = K_NOP;
        endcase
      end
      OPC_ADDI: begin kind_o = K_IMM; op_o = ALU_ADD; end
      OPC_SUBI: begin kind_o = K_IMM; op_o = ALU_SUB; end
      OPC_ANDI: begin kind_o = K_IMM; op_o = ALU_AND; end
      OPC_ORI:  begin kind_o = K_IMM; op_o = ALU_OR;  end
      OPC_XORI: begin kind_o = K_IMM; op_o = ALU_XOR; end
      OPC_SLTI: begin kind_o = K_IMM; op_o = ALU_SLT; end
      OPC_LW:   kind_o = K_LOAD;
      OPC_SW:   kind_o = K_STORE;
      OPC_BEQZ: kind_o = K_BRZ;
      OPC_BNEZ: kind_o = K_BRNZ;
      OPC_J:    kind_o = K_JUMP;
      default:  kind_o = K_NOP;
    endcase
  end
endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLL: y_o = a_i << sh;
      ALU_SRL: y_o = a_i >> sh;
      ALU_SRA: y_o = W'($signed(a_i) >>> sh);
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i
);
  logic [W-1:0] mem_q [NREG];

  // entry 0 is never written; reads of it are forced to zero
  always_ff @(posedge clk_i) begin
    if (we_i && waddr_i != '0) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = (raddr_a_i == '0) ? '0 : mem_q[raddr_a_i];
  assign rdata_b_o = (raddr_b_i == '0) ? '0 : mem_q[raddr_b_i];
endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            imem_req_o,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic            dmem_re_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            misalign_o
);
  localparam int IMMW = 16;
  localparam int JOFW = 26;

  phase_e          phase_q, phase_d;
  logic [XLEN-1:0] pc_q, ir_q, npc_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic            cond_q;

  kind_e           kind;
  alu_op_e         dec_op;
  logic [XLEN-1:0] rf_a, rf_b, rf_wdata;
  logic [RAW-1:0]  rf_waddr;
  logic            rf_we;

  logic [XLEN-1:0] alu_a, alu_b, alu_y, jof;
  alu_op_e         alu_op;
  logic            is_flow, is_mem, mis_addr;

  mcore_decode u_dec (
    .opc_i  (ir_q[31:26]),
    .fn_i   (ir_q[10:0]),
    .kind_o (kind),
    .op_o   (dec_op)
  );

  mcore_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .raddr_a_i (ir_q[25:21]),
    .raddr_b_i (ir_q[20:16]),
    .rdata_a_o (rf_a),
    .rdata_b_o (rf_b),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata)
  );

  // execute operand select: targets and addresses share the ALU adder
  assign is_flow = (kind == K_BRZ) || (kind == K_BRNZ) || (kind == K_JUMP);
  assign is_mem  = (kind == K_LOAD) || (kind == K_STORE);
  assign jof     = {{(XLEN-JOFW){ir_q[JOFW-1]}}, ir_q[JOFW-1:0]};
  assign alu_a   = is_flow ? npc_q : a_q;
  assign alu_op  = (kind == K_REG || kind == K_IMM) ? dec_op : ALU_ADD;

  always_comb begin
    unique case (kind)
      K_REG:   alu_b = b_q;
      K_JUMP:  alu_b = jof;
      default: alu_b = imm_q;
    endcase
  end

  mcore_alu #(.W(XLEN)) u_alu (
    .op_i (alu_op),
    .a_i  (alu_a),
    .b_i  (alu_b),
    .y_o  (alu_y)
  );

  // phase sequencer
  always_comb begin
    unique case (phase_q)
      PH_IF:   phase_d = PH_ID;
      PH_ID:   phase_d = PH_EX;
      PH_EX:   phase_d = PH_MEM;
      PH_MEM:  phase_d = PH_WB;
      default: phase_d = PH_IF;
    endcase
  end

  assign mis_addr = alu_q[1:0] != 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IF;
      pc_q    <= RESET_PC;
      ir_q    <= '0;
      npc_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      imm_q   <= '0;
      alu_q   <= '0;
      lmd_q   <= '0;
      cond_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      unique case (phase_q)
        PH_IF: begin
          ir_q  <= imem_rdata_i;
          npc_q <= pc_q + XLEN'(4);
        end
        PH_ID: begin
          a_q   <= rf_a;
          b_q   <= rf_b;
          imm_q <= {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
        end
        PH_EX: begin
          alu_q <= alu_y;
          unique case (kind)
            K_BRZ:   cond_q <= (a_q == '0);
            K_BRNZ:  cond_q <= (a_q != '0);
            K_JUMP:  cond_q <= 1'b1;
            default: cond_q <= 1'b0;
          endcase
        end
        PH_MEM: begin
          if (dmem_re_o) lmd_q <= dmem_rdata_i;
          pc_q <= cond_q ? alu_q : npc_q;
        end
        default: ;
      endcase
    end
  end

  // write-back
  assign rf_we    = (phase_q == PH_WB) &&
                    ((kind == K_REG) || (kind == K_IMM) || (kind == K_LOAD && !mis_addr));
  assign rf_waddr = (kind == K_REG) ? ir_q[15:11] : ir_q[20:16];
  assign rf_wdata = (kind == K_LOAD) ? lmd_q : alu_q;

  // ports
  assign imem_req_o   = (phase_q == PH_IF);
  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = alu_q;
  assign dmem_wdata_o = b_q;
  assign dmem_re_o    = (phase_q == PH_MEM) && (kind == K_LOAD)  && !mis_addr;
  assign dmem_we_o    = (phase_q == PH_MEM) && (kind == K_STORE) && !mis_addr;
  assign misalign_o   = (phase_q == PH_MEM) && is_mem && mis_addr;
endmodule

// File: rtl/mcore_checker.sv
module mcore_checker
  import mcore_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input phase_e          phase_q,
  input logic            imem_req_o,
  input logic [XLEN-1:0] imem_addr_o,
  input logic            dmem_re_o,
  input logic            dmem_we_o,
  input logic [XLEN-1:0] dmem_addr_o,
  input logic            misalign_o,
  input logic [XLEN-1:0] ir_q,
  input logic [XLEN-1:0] npc_q,
  input logic [XLEN-1:0] a_q,
  input logic [XLEN-1:0] alu_q,
  input logic            cond_q
);
  p_if_id_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_IF |=> phase_q == PH_ID);
  p_id_ex_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_ID |=> phase_q == PH_EX);
  p_ex_mem_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_EX |=> phase_q == PH_MEM);
  p_mem_wb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_MEM |=> phase_q == PH_WB);
  p_wb_if_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_WB |=> phase_q == PH_IF);
  p_req_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o |=> !imem_req_o);

  p_pc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != PH_WB |-> $stable(imem_addr_o));
  p_npc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_ID |-> npc_q == imem_addr_o + 32'd4);

  p_a_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_EX && ir_q[25:21] == 5'd0) |-> a_q == '0);

  p_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WB && $past(cond_q)) |-> imem_addr_o == $past(alu_q));
  p_fallthru_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WB && !$past(cond_q)) |-> imem_addr_o == $past(npc_q));

  p_aligned_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_we_o || dmem_re_o) |-> dmem_addr_o[1:0] == 2'b00);
  p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> !(dmem_we_o || dmem_re_o));
  p_err_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |=> !misalign_o);
endmodule

bind mcore_top mcore_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_q     (phase_q),
  .imem_req_o  (imem_req_o),
  .imem_addr_o (imem_addr_o),
  .dmem_re_o   (dmem_re_o),
  .dmem_we_o   (dmem_we_o),
  .dmem_addr_o (dmem_addr_o),
  .misalign_o  (misalign_o),
  .ir_q        (ir_q),
  .npc_q       (npc_q),
  .a_q         (a_q),
  .alu_q       (alu_q),
  .cond_q      (cond_q)
);

// File: tb/mcore_top_bench.sv
`timescale 1ns/1ps
module mcore_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req, dmem_re, dmem_we, misalign;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;

  always #4 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  mcore_top u_mcore_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .imem_req_o   (imem_req),
    .imem_addr_o  (imem_addr),
    .imem_rdata_i (imem_rdata),
    .dmem_re_o    (dmem_re),
    .dmem_we_o    (dmem_we),
    .dmem_addr_o  (dmem_addr),
    .dmem_wdata_o (dmem_wdata),
    .dmem_rdata_i (dmem_rdata),
    .misalign_o   (misalign)
  );

  int n_chk = 0, n_err = 0, err_cnt = 0, we_cnt = 0, cyc = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n && misalign) err_cnt++;
    if (rst_n && dmem_we)  we_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rd,
                                        input logic [4:0] rs1, input logic [4:0] rs2);
    return {6'h00, rs1, rs2, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rd,
                                        input logic [4:0] rs1, input logic [15:0] imm);
    return {op, rs1, rd, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] off);
    return {6'h02, off};
  endfunction

  localparam logic [31:0] HALT = {6'h02, 26'h3FF_FFFC};

  // hold reset, clear memories, counters zeroed
  task automatic begin_reset;
    rst_n = 1'b0;
    for (int k = 0; k < 64; k++) begin imem[k] = 32'h0; dmem[k] = 32'h0; end
    err_cnt = 0; we_cnt = 0;
  endtask
  task automatic release_reset;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  typedef struct packed {
    logic        is_imm;
    logic [5:0]  code;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 6'h20, 32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},  // ADD
    '{1'b0, 6'h22, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},  // SUB
    '{1'b0, 6'h24, 32'hF0F0_1234, 32'h0FF0_FFFF, 32'h00F0_1234},  // AND
    '{1'b0, 6'h25, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},  // OR
    '{1'b0, 6'h26, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},  // XOR
    '{1'b0, 6'h04, 32'h8000_0003, 32'h0000_0024, 32'h0000_0030},  // SLL by low 5 bits
    '{1'b0, 6'h06, 32'h8000_0000, 32'h0000_0004, 32'h0800_0000},  // SRL
    '{1'b0, 6'h07, 32'h8000_0000, 32'h0000_0004, 32'hF800_0000},  // SRA
    '{1'b0, 6'h2A, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},  // SLT -1<1
    '{1'b0, 6'h2A, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},  // SLT 1<-1
    '{1'b1, 6'h08, 32'h0000_000A, 32'h0000_FFFF, 32'h0000_0009},  // ADDI -1
    '{1'b1, 6'h0A, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF},  // SUBI
    '{1'b1, 6'h0C, 32'h1234_5678, 32'h0000_8F0F, 32'h1234_0608},  // ANDI sext
    '{1'b1, 6'h0D, 32'h0000_0000, 32'h0000_7FFF, 32'h0000_7FFF},  // ORI
    '{1'b1, 6'h0E, 32'hFFFF_FFFF, 32'h0000_00FF, 32'hFFFF_FF00},  // XORI
    '{1'b1, 6'h18, 32'h0000_0003, 32'h0000_8000, 32'h0000_0000}   // SLTI 3<-32768
  };

  task automatic load_vec(input vec_t v);
    dmem[0] = v.a;
    dmem[1] = v.b;
    dmem[2] = 32'hDEAD_BEEF;
    imem[0] = enc_i(6'h23, 5'd1, 5'd0, 16'd0);
    imem[1] = enc_i(6'h23, 5'd2, 5'd0, 16'd4);
    imem[2] = v.is_imm ? enc_i(v.code, 5'd3, 5'd1, v.b[15:0])
                       : enc_r(v.code, 5'd3, 5'd1, 5'd2);
    imem[3] = enc_i(6'h2B, 5'd3, 5'd0, 16'd8);
    imem[4] = HALT;
  endtask

  initial begin
    logic [31:0] exp_addr;
    @(negedge clk);

    // R1: reset state, then R2/R3 fetch timing on the first vector program
    begin_reset;
    load_vec(VECS[0]);
    @(negedge clk);
    chk("R1 imem_addr in reset", imem_addr, 32'h0);
    chk("R1 strobes in reset", {29'd0, dmem_re, dmem_we, misalign}, 32'h0);
    release_reset;
    for (int c = 0; c < 16; c++) begin
      exp_addr = 32'(4 * (c / 5));
      if (c % 5 == 4) exp_addr = 32'(4 * (c / 5 + 1));
      chk($sformatf("R2 imem_req cycle %0d", c), {31'd0, imem_req}, {31'd0, (c % 5 == 0)});
      chk($sformatf("R3 pc cycle %0d", c), imem_addr, exp_addr);
      @(negedge clk);
    end

    // R4 R5 R6: vector table
    for (int i = 0; i < NVEC; i++) begin
      begin_reset;
      load_vec(VECS[i]);
      release_reset;
      repeat (30) @(negedge clk);
      chk($sformatf("%s vec %0d result (R6 dest field)", VECS[i].is_imm ? "R5" : "R4", i),
          dmem[2], VECS[i].exp);
    end

    // R8 R9 R10: branch and jump program
    begin_reset;
    imem[0]  = enc_i(6'h08, 5'd5, 5'd0, 16'd9);
    imem[1]  = enc_i(6'h23, 5'd1, 5'd0, 16'd0);
    imem[2]  = enc_i(6'h04, 5'd0, 5'd1, 16'd8);     // BEQZ taken -> 20
    imem[3]  = enc_i(6'h08, 5'd5, 5'd0, 16'd1);
    imem[4]  = enc_i(6'h08, 5'd5, 5'd0, 16'd2);
    imem[5]  = enc_i(6'h05, 5'd0, 5'd1, 16'd8);     // BNEZ not taken
    imem[6]  = enc_i(6'h08, 5'd6, 5'd0, 16'h0077);
    imem[7]  = enc_i(6'h05, 5'd0, 5'd6, 16'd4);     // BNEZ taken -> 36
    imem[8]  = enc_i(6'h08, 5'd6, 5'd0, 16'h0011);
    imem[9]  = enc_i(6'h04, 5'd0, 5'd6, 16'd4);     // BEQZ not taken
    imem[10] = enc_i(6'h08, 5'd7, 5'd0, 16'd3);
    imem[11] = enc_j(26'd8);                        // J -> 56
    imem[12] = enc_i(6'h08, 5'd7, 5'd0, 16'd4);
    imem[13] = enc_i(6'h08, 5'd7, 5'd0, 16'd5);
    imem[14] = enc_i(6'h08, 5'd8, 5'd0, 16'h0040);
    imem[15] = enc_i(6'h2B, 5'd5, 5'd8, 16'hFFF8);  // 0x38
    imem[16] = enc_i(6'h2B, 5'd6, 5'd8, 16'hFFFC);  // 0x3C
    imem[17] = enc_i(6'h2B, 5'd7, 5'd8, 16'h0000);  // 0x40
    imem[18] = HALT;
    release_reset;
    repeat (100) @(negedge clk);
    chk("R9 BEQZ taken skips, R8 negative offset", dmem[14], 32'd9);
    chk("R9 BNEZ taken skips, BNEZ untaken falls through", dmem[15], 32'h77);
    chk("R10 J forward skips, BEQZ untaken falls through", dmem[16], 32'd3);
    chk("R10 self jump holds pc", imem_addr, 32'd72);

    // R7 R11 R12: zero register, misaligned and undefined instructions
    begin_reset;
    dmem[0] = 32'h1111_1111;
    dmem[1] = 32'h2222_2222;
    dmem[2] = 32'hFFFF_FFFF;
    dmem[3] = 32'h0;
    imem[0] = enc_i(6'h23, 5'd2, 5'd0, 16'd4);
    imem[1] = enc_i(6'h08, 5'd0, 5'd0, 16'h0055);
    imem[2] = enc_r(6'h20, 5'd0, 5'd2, 5'd2);
    imem[3] = enc_i(6'h2B, 5'd0, 5'd0, 16'd8);
    imem[4] = enc_i(6'h23, 5'd2, 5'd0, 16'd2);      // misaligned load
    imem[5] = enc_i(6'h2B, 5'd2, 5'd0, 16'd6);      // misaligned store
    imem[6] = enc_i(6'h3F, 5'd2, 5'd0, 16'd1);      // undefined opcode
    imem[7] = enc_r(6'h3F, 5'd2, 5'd0, 5'd0);       // undefined func
    imem[8] = enc_i(6'h2B, 5'd2, 5'd0, 16'd12);
    imem[9] = HALT;
    release_reset;
    for (int c = 0; c < 60; c++) begin
      if (c >= 22 && c <= 24)
        chk($sformatf("R11 misalign cycle %0d", c), {31'd0, misalign}, {31'd0, c == 23});
      @(negedge clk);
    end
    chk("R7 r0 reads zero after writes", dmem[2], 32'h0);
    chk("R11 misalign pulse count", err_cnt, 32'd2);
    chk("R11 write strobe count", we_cnt, 32'd2);
    chk("R11 misaligned store dropped", dmem[1], 32'h2222_2222);
    chk("R12 r2 unchanged by bad load and undefined ops", dmem[3], 32'h2222_2222);
    chk("R12 pc advanced to halt", imem_addr, 32'd36);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule